// File: doc/BRIEF.md
# Bus Master-Abort Monitor

This block sits beside the initiator side of a parallel bus interface and decides when an outbound transaction has ended in a master abort. It detects an abort in two ways. The first is a device-select timeout: after the initiator drives its frame strobe low, a target must claim the cycle by driving device-select low within a fixed number of clocks. The limit depends on the bus mode. The second is a decoded split-completion error message: a bridge further down the bus reports that it saw an abort while forwarding a split read request.

Each abort updates sticky status bits, can raise a one-clock system-error pulse, and stops the DMA engine's view of progress by raising an error flag and dropping the active flag. Software clears status bits through a write-one-to-clear strobe. The DMA engine marks a new run with a start strobe.

Top module: `mabort_monitor`

## Requirements
- R1: In conventional mode (`ext_mode`=0), a transaction starts on the edge where `frame_n` is first sampled low. If `devsel_n` is not sampled low on any of the next 5 edges, the 5th of those edges detects a master abort and sets `status` bit 13. A low `devsel_n` on the 5th edge means no abort.
- R2: In extended mode (`ext_mode`=1, latched at the starting edge), the device-select window is 7 edges instead of 5.
- R3: In extended mode, a message with `msg_valid`=1, `msg_class`=4'h1 and `msg_index`=8'h00 is a master abort. It sets `status` bit 13 and the split-error-received bit, `status` bit 9, on that edge.
- R4: A message with any other class or index, or any message while `ext_mode`=0, changes no status bit and no DMA flag.
- R5: A timeout abort on an MSI write (`xact_kind`=2'b10, latched at the starting edge) while `serr_en`=1 drives `serr_n` low for exactly one clock after the detecting edge and sets `status` bit 14. Aborts on read (2'b00), write (2'b01) or read completion (2'b11), aborts with `serr_en`=0, and message aborts leave `serr_n` high.
- R6: Any master abort sets `dma_err` and clears `dma_act`. `dma_start` sets `dma_act` and clears `dma_err`. If an abort and `dma_start` fall in the same cycle, the abort wins.
- R7: Status bits are sticky. When `clr_valid`=1, each bit with a one in `clr_mask` is cleared, unless that bit is being set in the same cycle, in which case it stays set.
- R8: The timeout counter disarms when `devsel_n` is sampled low or when `frame_n` is released. A frame held low after an abort does not produce a second abort, and releasing `frame_n` before the limit produces none.
- R9: After reset, `status` is zero, `serr_n` is high, and `dma_err` and `dma_act` are low.
- R10: A timeout abort and a qualifying message on the same edge apply the effects of both sources: bits 13, 14 and 9 are set, and there is a single one-clock `serr_n` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Initiator frame strobe, active low |
| devsel_n | input | 1 | Target claim strobe, active low |
| ext_mode | input | 1 | 1 = extended split-transaction mode, 0 = conventional |
| xact_kind | input | 2 | Outbound transaction type: 00 read, 01 write, 10 MSI write, 11 read completion |
| serr_en | input | 1 | System-error signalling enable |
| msg_valid | input | 1 | Decoded split-completion error message present |
| msg_class | input | 4 | Message class field |
| msg_index | input | 8 | Message index field |
| clr_valid | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | 16 | Bits of `status` to clear |
| dma_start | input | 1 | DMA run start |
| status | output | 16 | Sticky status word (13 master abort, 14 system error raised, 9 split error received) |
| serr_n | output | 1 | System-error pulse, active low |
| dma_err | output | 1 | DMA error flag |
| dma_act | output | 1 | DMA active flag |

## Verification
Two things can happen on the same edge: the device-select timeout expiring and a qualifying split-completion error message being decoded. The bench forces this in extended mode. It starts an MSI write that no target claims, and it presents the abort message just before the 7th edge. The result must show all three status bits set and exactly one `serr_n` low cycle. A second collision, a clear strobe that lands on the edge where a bit is being set, is provoked by sending a message together with a clear mask covering bits 13 and 9. Both bits must still read one afterwards.

// File: rtl/mabort_pkg.sv
package mabort_pkg;

   typedef enum logic [1:0] {
      KIND_READ  = 2'b00,
      KIND_WRITE = 2'b01,
      KIND_MSI   = 2'b10,
      KIND_RDCPL = 2'b11
   } xact_kind_e;

   typedef enum logic [1:0] {
      TMR_IDLE  = 2'b00,
      TMR_COUNT = 2'b01,
      TMR_HOLD  = 2'b10
   } tmr_state_e;

endpackage

// File: rtl/mabort_timer.sv
module mabort_timer
   import mabort_pkg::*;
#(
   parameter int CONV_LIMIT = 5,
   parameter int EXT_LIMIT  = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_n,
   input  logic       devsel_n,
   input  logic       ext_mode,
   input  logic [1:0] kind_in,
   output logic       abort_o,
   output logic [1:0] kind_o
);

   localparam int MAX_LIMIT = (EXT_LIMIT > CONV_LIMIT) ? EXT_LIMIT : CONV_LIMIT;
   localparam int CNT_W     = $clog2(MAX_LIMIT + 1);
   localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_LIMIT - 1);
   localparam logic [CNT_W-1:0] EXT_LAST  = CNT_W'(EXT_LIMIT - 1);

   tmr_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_q;
   logic [1:0]       kind_q;
   logic             expire;

   // window closes on the edge where the count reaches the latched limit
   assign expire  = (state_q == TMR_COUNT) && !frame_n && devsel_n && (cnt_q == last_q);
   assign abort_o = expire;
   assign kind_o  = kind_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TMR_IDLE;
         cnt_q   <= '0;
         last_q  <= CONV_LAST;
         kind_q  <= KIND_READ;
      end else begin
         unique case (state_q)
            TMR_IDLE: begin
               if (!frame_n) begin
                  cnt_q  <= '0;
                  last_q <= ext_mode ? EXT_LAST : CONV_LAST;
                  kind_q <= kind_in;
                  state_q <= devsel_n ? TMR_COUNT : TMR_HOLD;
               end
            end
            TMR_COUNT: begin
               if (frame_n) begin
                  state_q <= TMR_IDLE;
               end else if (!devsel_n || expire) begin
                  state_q <= TMR_HOLD;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            TMR_HOLD: begin
               if (frame_n) state_q <= TMR_IDLE;
            end
            default: state_q <= TMR_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/mabort_splitdec.sv
module mabort_splitdec #(
   parameter int               CLASS_W     = 4,
   parameter int               INDEX_W     = 8,
   parameter logic [CLASS_W-1:0] ABORT_CLASS = 4'h1,
   parameter logic [INDEX_W-1:0] ABORT_INDEX = 8'h00,
   parameter bit               SPLIT_EN    = 1'b1
) (
   input  logic               msg_valid,
   input  logic               ext_mode,
   input  logic [CLASS_W-1:0] msg_class,
   input  logic [INDEX_W-1:0] msg_index,
   output logic               hit_o
);

   generate
      if (SPLIT_EN) begin : g_decode
         assign hit_o = msg_valid && ext_mode &&
                        (msg_class == ABORT_CLASS) && (msg_index == ABORT_INDEX);
      end else begin : g_absent
         logic unused_in;
         assign unused_in = msg_valid ^ ext_mode ^ (^msg_class) ^ (^msg_index);
         assign hit_o     = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/mabort_status.sv
module mabort_status #(
   parameter int STAT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] set_i,
   input  logic              clr_valid,
   input  logic [STAT_W-1:0] clr_mask,
   output logic [STAT_W-1:0] stat_o
);

   logic [STAT_W-1:0] bits_q;

   generate
      for (genvar b = 0; b < STAT_W; b++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         bits_q[b] <= 1'b0;
            else if (set_i[b])                  bits_q[b] <= 1'b1;
            else if (clr_valid && clr_mask[b])  bits_q[b] <= 1'b0;
         end
      end
   endgenerate

   assign stat_o = bits_q;

endmodule

// File: rtl/mabort_monitor.sv
module mabort_monitor
   import mabort_pkg::*;
#(
   parameter int STAT_W      = 16,
   parameter int CONV_LIMIT  = 5,
   parameter int EXT_LIMIT   = 7,
   parameter int MA_BIT      = 13,
   parameter int SERR_BIT    = 14,
   parameter int SPLIT_BIT   = 9,
   parameter int CLASS_W     = 4,
   parameter int INDEX_W     = 8,
   parameter int ABORT_CLASS = 1,
   parameter int ABORT_INDEX = 0,
   parameter bit SPLIT_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_n,
   input  logic              devsel_n,
   input  logic              ext_mode,
   input  logic [1:0]        xact_kind,
   input  logic              serr_en,
   input  logic              msg_valid,
   input  logic [CLASS_W-1:0] msg_class,
   input  logic [INDEX_W-1:0] msg_index,
   input  logic              clr_valid,
   input  logic [STAT_W-1:0] clr_mask,
   input  logic              dma_start,
   output logic [STAT_W-1:0] status,
   output logic              serr_n,
   output logic              dma_err,
   output logic              dma_act
);

   generate
      if (CONV_LIMIT < 1 || EXT_LIMIT < 1) begin : g_bad_limit
         $error("device-select limits must be at least one clock");
      end
      if (MA_BIT >= STAT_W || SERR_BIT >= STAT_W || SPLIT_BIT >= STAT_W) begin : g_bad_pos
         $error("status bit position outside status word");
      end
      if (MA_BIT == SERR_BIT || MA_BIT == SPLIT_BIT || SERR_BIT == SPLIT_BIT) begin : g_bad_dup
         $error("status bit positions must be distinct");
      end
   endgenerate

   logic              to_abort;
   logic [1:0]        to_kind;
   logic              split_abort;
   logic              abort_any;
   logic              serr_fire;
   logic [STAT_W-1:0] set_vec;

   mabort_timer #(
      .CONV_LIMIT (CONV_LIMIT),
      .EXT_LIMIT  (EXT_LIMIT)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_n  (frame_n),
      .devsel_n (devsel_n),
      .ext_mode (ext_mode),
      .kind_in  (xact_kind),
      .abort_o  (to_abort),
      .kind_o   (to_kind)
   );

   mabort_splitdec #(
      .CLASS_W     (CLASS_W),
      .INDEX_W     (INDEX_W),
      .ABORT_CLASS (CLASS_W'(ABORT_CLASS)),
      .ABORT_INDEX (INDEX_W'(ABORT_INDEX)),
      .SPLIT_EN    (SPLIT_EN)
   ) u_split (
      .msg_valid (msg_valid),
      .ext_mode  (ext_mode),
      .msg_class (msg_class),
      .msg_index (msg_index),
      .hit_o     (split_abort)
   );

   assign abort_any = to_abort || split_abort;
   assign serr_fire = to_abort && (to_kind == KIND_MSI) && serr_en;

   always_comb begin
      set_vec            = '0;
      set_vec[MA_BIT]    = abort_any;
      set_vec[SERR_BIT]  = serr_fire;
      set_vec[SPLIT_BIT] = split_abort;
   end

   mabort_status #(
      .STAT_W (STAT_W)
   ) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (set_vec),
      .clr_valid (clr_valid),
      .clr_mask  (clr_mask),
      .stat_o    (status)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         serr_n  <= 1'b1;
         dma_err <= 1'b0;
         dma_act <= 1'b0;
      end else begin
         serr_n <= !serr_fire;
         if (abort_any) begin
            dma_err <= 1'b1;
            dma_act <= 1'b0;
         end else if (dma_start) begin
            dma_err <= 1'b0;
            dma_act <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/mabort_monitor_chk.sv
module mabort_monitor_chk (
   input logic clk,
   input logic rst_n,
   input logic to_abort,
   input logic split_abort,
   input logic abort_any,
   input logic ext_mode,
   input logic msg_valid,
   input logic serr_n,
   input logic serr_flag,
   input logic ma_flag,
   input logic ma_clr,
   input logic split_flag,
   input logic dma_err,
   input logic dma_act
);

   AST_MA_SET: assert property (@(posedge clk) disable iff (!rst_n)
      to_abort |=> ma_flag); // R1

   AST_SPLIT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      split_abort |=> (split_flag && ma_flag)); // R3

   AST_SPLIT_CONV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !ext_mode) |-> !split_abort); // R4

   AST_SERR_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      !serr_n |=> serr_n); // R5

   AST_SERR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(serr_n) |-> serr_flag); // R5

   AST_DMA_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      abort_any |=> (dma_err && !dma_act)); // R6

   AST_MA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ma_flag && !ma_clr) |=> ma_flag); // R7

   AST_TO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      to_abort |=> !to_abort); // R8

endmodule

bind mabort_monitor mabort_monitor_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .to_abort    (to_abort),
   .split_abort (split_abort),
   .abort_any   (abort_any),
   .ext_mode    (ext_mode),
   .msg_valid   (msg_valid),
   .serr_n      (serr_n),
   .serr_flag   (status[SERR_BIT]),
   .ma_flag     (status[MA_BIT]),
   .ma_clr      (clr_valid && clr_mask[MA_BIT]),
   .split_flag  (status[SPLIT_BIT]),
   .dma_err     (dma_err),
   .dma_act     (dma_act)
);

// File: tb/mabort_monitor_tb.sv
module mabort_monitor_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_n = 1'b1;
   logic        devsel_n = 1'b1;
   logic        ext_mode = 1'b0;
   logic [1:0]  xact_kind = 2'b00;
   logic        serr_en = 1'b0;
   logic        msg_valid = 1'b0;
   logic [3:0]  msg_class = 4'h0;
   logic [7:0]  msg_index = 8'h00;
   logic        clr_valid = 1'b0;
   logic [15:0] clr_mask = 16'h0;
   logic        dma_start = 1'b0;
   logic [15:0] status;
   logic        serr_n;
   logic        dma_err;
   logic        dma_act;

   int total = 0;
   int bad = 0;
   int serr_lows = 0;
   bit done = 1'b0;

   localparam logic [15:0] B_MA = 16'h2000;
   localparam logic [15:0] B_SE = 16'h4000;
   localparam logic [15:0] B_SP = 16'h0200;

   always #10 clk = ~clk;

   mabort_monitor u_dut (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .devsel_n(devsel_n),
      .ext_mode(ext_mode), .xact_kind(xact_kind), .serr_en(serr_en),
      .msg_valid(msg_valid), .msg_class(msg_class), .msg_index(msg_index),
      .clr_valid(clr_valid), .clr_mask(clr_mask), .dma_start(dma_start),
      .status(status), .serr_n(serr_n), .dma_err(dma_err), .dma_act(dma_act)
   );

   always @(negedge clk) if (rst_n && !serr_n) serr_lows++;

   // {mode, kind[1:0], serr_en, dly[3:0], exp_ma, exp_serr}; dly 0 = never claimed
   localparam int NV = 12;
   localparam logic [9:0] VEC [NV] = '{
      {1'b0, 2'b00, 1'b0, 4'd3, 1'b0, 1'b0},   // R1 early claim
      {1'b0, 2'b00, 1'b0, 4'd5, 1'b0, 1'b0},   // R1 claim on last edge
      {1'b0, 2'b00, 1'b0, 4'd6, 1'b1, 1'b0},   // R1 one edge late
      {1'b0, 2'b00, 1'b1, 4'd0, 1'b1, 1'b0},   // R1 R5 read never claimed
      {1'b1, 2'b00, 1'b0, 4'd6, 1'b0, 1'b0},   // R2 claim at 6 is fine
      {1'b1, 2'b01, 1'b0, 4'd7, 1'b0, 1'b0},   // R2 claim on last edge
      {1'b1, 2'b01, 1'b0, 4'd8, 1'b1, 1'b0},   // R2 one edge late
      {1'b0, 2'b10, 1'b1, 4'd0, 1'b1, 1'b1},   // R5 R8 MSI with enable
      {1'b0, 2'b10, 1'b0, 4'd0, 1'b1, 1'b0},   // R5 MSI without enable
      {1'b1, 2'b10, 1'b1, 4'd8, 1'b1, 1'b1},   // R2 R5 MSI ext mode
      {1'b0, 2'b01, 1'b1, 4'd0, 1'b1, 1'b0},   // R5 plain write
      {1'b0, 2'b11, 1'b1, 4'd1, 1'b0, 1'b0}    // R1 read completion claimed
   };

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic clear_all();
      @(negedge clk);
      clr_valid = 1'b1; clr_mask = 16'hFFFF; dma_start = 1'b1;
      @(negedge clk);
      clr_valid = 1'b0; clr_mask = 16'h0; dma_start = 1'b0;
   endtask

   // frame low from edge E0 for 'hold' edges; devsel low from edge E'dly';
   // abort message presented on edge E'msg_at'
   task automatic run_xact(input logic m, input logic [1:0] k, input logic se,
                           input int dly, input int msg_at, input int hold);
      @(negedge clk);
      ext_mode = m; xact_kind = k; serr_en = se;
      frame_n = 1'b0; devsel_n = 1'b1;
      for (int e = 1; e < hold; e++) begin
         @(negedge clk);
         msg_valid = 1'b0;
         if (e == dly) devsel_n = 1'b0;
         if (e == msg_at) begin
            msg_valid = 1'b1; msg_class = 4'h1; msg_index = 8'h00;
         end
      end
      @(negedge clk);
      msg_valid = 1'b0; frame_n = 1'b1; devsel_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic send_msg(input logic m, input logic [3:0] c, input logic [7:0] i);
      @(negedge clk);
      ext_mode = m; msg_valid = 1'b1; msg_class = c; msg_index = i;
      @(negedge clk);
      msg_valid = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int base;
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9", "status", status, 0);
      check("R9", "serr_n", serr_n, 1);
      check("R9", "dma_err", dma_err, 0);
      check("R9", "dma_act", dma_act, 0);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         logic [9:0] t;
         logic [15:0] exp_st;
         t = VEC[v];
         clear_all();
         base = serr_lows;
         run_xact(t[9], t[8:7], t[6], int'(t[5:2]), -1, 12);
         exp_st = (t[1] ? B_MA : 16'h0) | (t[0] ? B_SE : 16'h0);
         check("R1/R2 vector", $sformatf("status v%0d", v), status, exp_st);
         check("R5 vector", $sformatf("serr pulses v%0d", v), serr_lows - base, t[0] ? 1 : 0);
         check("R6 vector", $sformatf("dma_err v%0d", v), dma_err, t[1]);
         check("R6 vector", $sformatf("dma_act v%0d", v), dma_act, !t[1]);
      end

      // R8 frame released before the limit without a claim
      clear_all();
      run_xact(1'b0, 2'b10, 1'b1, 0, -1, 3);
      check("R8", "early release status", status, 0);
      check("R8", "early release dma_act", dma_act, 1);

      // R3 split abort in ext mode, R5 no system error for it
      clear_all();
      base = serr_lows;
      serr_en = 1'b1; xact_kind = 2'b10;
      send_msg(1'b1, 4'h1, 8'h00);
      check("R3", "split status", status, B_MA | B_SP);
      check("R5", "split serr pulses", serr_lows - base, 0);
      check("R6", "split dma_err", dma_err, 1);
      check("R6", "split dma_act", dma_act, 0);

      // R4 ignored messages
      clear_all();
      send_msg(1'b1, 4'h2, 8'h00);
      send_msg(1'b1, 4'h1, 8'h01);
      send_msg(1'b0, 4'h1, 8'h00);
      check("R4", "ignored status", status, 0);
      check("R4", "ignored dma_act", dma_act, 1);
      check("R4", "ignored dma_err", dma_err, 0);

      // R7 set wins over same-cycle clear, then selective clear
      clear_all();
      @(negedge clk);
      ext_mode = 1'b1; msg_valid = 1'b1; msg_class = 4'h1; msg_index = 8'h00;
      clr_valid = 1'b1; clr_mask = B_MA | B_SP;
      @(negedge clk);
      msg_valid = 1'b0; clr_valid = 1'b0; clr_mask = 16'h0;
      check("R7", "set beats clear", status, B_MA | B_SP);
      repeat (3) @(negedge clk);
      check("R7", "sticky hold", status, B_MA | B_SP);
      clr_valid = 1'b1; clr_mask = B_MA;
      @(negedge clk);
      clr_valid = 1'b0; clr_mask = 16'h0;
      check("R7", "selective clear", status, B_SP);

      // R6 abort beats dma_start in the same cycle
      clear_all();
      @(negedge clk);
      msg_valid = 1'b1; dma_start = 1'b1;
      @(negedge clk);
      msg_valid = 1'b0; dma_start = 1'b0;
      check("R6", "abort beats start err", dma_err, 1);
      check("R6", "abort beats start act", dma_act, 0);

      // R10 timeout and message on the same edge (ext limit edge 7)
      clear_all();
      base = serr_lows;
      run_xact(1'b1, 2'b10, 1'b1, 0, 7, 12);
      check("R10", "collision status", status, B_MA | B_SE | B_SP);
      check("R10", "collision serr pulses", serr_lows - base, 1);
      check("R10", "collision dma_err", dma_err, 1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule